// File: doc/BRIEF.md
# Processor Status Word and Condition Tester

This block keeps the eight-bit status word of a microprogrammed 16-bit processor: four arithmetic flags (zero, carry, negative, overflow), a link bit and three general-purpose user flags. Each cycle it can take the arithmetic flags from the ALU, under a status-enable control, and apply one explicit microinstruction operation: set a group of bits, clear a group of bits, or load the whole word. A group is named by a 5-bit code. Only five codes name a group.

A 4-bit condition select picks a single test bit for an external sequencer. The tests cover signed compares (less than, less or equal) and unsigned compares (lower or same), and can also read any single status bit. The word can be put onto a 16-bit save bus, so that microcode can store it into a register or route it to the accumulator or Y output. All updates are synchronous, and the reset is synchronous and active-high.

Top module: `status_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every status bit is cleared. After that edge the save bus shows 0x0000 when `save_en` is high.
- R2: `op`=1 (set) with `grp` 3 sets zero, carry, negative and overflow. Code 5 sets link, 6 sets user flag 1, 9 sets user flag 2 and 10 sets user flag 3. Bits outside the named group keep their values.
- R3: `op`=2 (clear) with the same codes (3, 5, 6, 9, 10) clears the same groups. Bits outside the named group keep their values.
- R4: A set or clear with any other group code changes no status bit.
- R5: `op`=3 (load) replaces the whole status word with `ld_word`, using the bit layout of R11.
- R6: When `alu_en` is high, zero, carry, negative and overflow take `alu_z`, `alu_c`, `alu_n` and `alu_ovr` at the clock edge. Link and the user flags are unchanged by this update.
- R7: When `alu_en` is low, the ALU flag inputs are ignored. With `op`=0 the word then holds its value.
- R8: When an ALU update and an explicit operation fall in the same cycle, the ALU update is applied first and the explicit operation second. The explicit operation therefore wins on every bit it touches, and a load wins on all bits.
- R9: `cond_out` is combinational from the stored word and `cond_sel`: 0 = (N xor OVR) or Z, 1 = N xor OVR, 2 = Z, 3 = OVR, 4 = LOW (carry clear or Z set), 5 = C, 6 = Z or C, 7 = N, 8 = link, 9 = flag 1, 10 = flag 2, 11 = flag 3.
- R10: `cond_sel` values 12 to 15 drive `cond_out` to 0.
- R11: With `save_en` high, `save_bus` shows the word with bit 0 = Z, 1 = C, 2 = N, 3 = OVR, 4 = link, 5 = flag 1, 6 = flag 2 and 7 = flag 3, and bits 15..8 are zero. With `save_en` low, `save_bus` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Explicit operation: 0 none, 1 set, 2 clear, 3 load |
| grp | input | 5 | Group code for set and clear |
| ld_word | input | 8 | Word to load, in the save-bus layout |
| alu_en | input | 1 | Status enable for the ALU flag update |
| alu_z | input | 1 | ALU zero result |
| alu_c | input | 1 | ALU carry result |
| alu_n | input | 1 | ALU negative result |
| alu_ovr | input | 1 | ALU overflow result |
| cond_sel | input | 4 | Condition test select |
| cond_out | output | 1 | Selected condition |
| save_en | input | 1 | Drive the status word onto the save bus |
| save_bus | output | 16 | Saved status word |

## Verification
The ALU flag update and an explicit set, clear or load can fall in the same cycle. The bench provokes this by raising `alu_en`, with flag values that differ from the outcome of the explicit operation, in the same cycle as a group-3 set, a group-3 clear, a load, and a link set.

Each result is judged on the save bus after the edge. The explicit operation's bits must show the explicit result, and any arithmetic flags it does not touch must show the ALU values. All twelve condition selects are then compared with tests computed from the bench's own copy of the word.

// File: rtl/status_pkg.sv
package status_pkg;

    localparam int STW_BITS  = 8;
    localparam int SAVE_BITS = 16;
    localparam int GRP_BITS  = 5;
    localparam int SEL_BITS  = 4;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_LOAD = 2'd3
    } st_op_e;

    // bit 0 is zero flag (last member)
    typedef struct packed {
        logic uf3;
        logic uf2;
        logic uf1;
        logic lnk;
        logic ovr;
        logic neg;
        logic cy;
        logic zr;
    } stword_t;

    typedef struct packed {
        logic zr;
        logic cy;
        logic neg;
        logic ovr;
    } aluflags_t;

    localparam logic [GRP_BITS-1:0] GRP_ARITH = 5'd3;
    localparam logic [GRP_BITS-1:0] GRP_LINK  = 5'd5;
    localparam logic [GRP_BITS-1:0] GRP_UF1   = 5'd6;
    localparam logic [GRP_BITS-1:0] GRP_UF2   = 5'd9;
    localparam logic [GRP_BITS-1:0] GRP_UF3   = 5'd10;

    function automatic logic [STW_BITS-1:0] grp_mask(input logic [GRP_BITS-1:0] g);
        logic [STW_BITS-1:0] m;
        unique case (g)
            GRP_ARITH: m = 8'h0F;
            GRP_LINK:  m = 8'h10;
            GRP_UF1:   m = 8'h20;
            GRP_UF2:   m = 8'h40;
            GRP_UF3:   m = 8'h80;
            default:   m = 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/status_next.sv
module status_next
    import status_pkg::*;
(
    input  stword_t                cur,
    input  st_op_e                 op,
    input  logic [GRP_BITS-1:0]    grp,
    input  logic [STW_BITS-1:0]    ld_word,
    input  logic                   alu_en,
    input  aluflags_t              alu,
    output stword_t                nxt
);
    stword_t             after_alu;
    logic [STW_BITS-1:0] mask;

    assign mask = grp_mask(grp);

    always_comb begin
        after_alu = cur;
        if (alu_en) begin
            after_alu.zr  = alu.zr;
            after_alu.cy  = alu.cy;
            after_alu.neg = alu.neg;
            after_alu.ovr = alu.ovr;
        end
    end

    always_comb begin
        unique case (op)
            OP_SET:  nxt = stword_t'(after_alu | mask);
            OP_CLR:  nxt = stword_t'(after_alu & ~mask);
            OP_LOAD: nxt = stword_t'(ld_word);
            default: nxt = after_alu;
        endcase
    end
endmodule

// File: rtl/status_reg.sv
module status_reg
    import status_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  stword_t nxt,
    output stword_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/status_cond.sv
module status_cond
    import status_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  stword_t             st,
    input  logic [SEL_BITS-1:0] sel,
    output logic                tst
);
    logic lt_signed;
    assign lt_signed = st.neg ^ st.ovr;

    always_comb begin
        unique case (sel)
            4'h0:    tst = lt_signed | st.zr;
            4'h1:    tst = lt_signed;
            4'h2:    tst = st.zr;
            4'h3:    tst = st.ovr;
            4'h4:    tst = ~st.cy | st.zr;
            4'h5:    tst = st.cy;
            4'h6:    tst = st.zr | st.cy;
            4'h7:    tst = st.neg;
            4'h8:    tst = st.lnk;
            4'h9:    tst = st.uf1;
            4'hA:    tst = st.uf2;
            4'hB:    tst = st.uf3;
            default: tst = 1'b0;
        endcase
    end

    // R10
    unused_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel >= 4'hC) |-> !tst);
endmodule

// File: rtl/status_unit.sv
module status_unit
    import status_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           op,
    input  logic [GRP_BITS-1:0]  grp,
    input  logic [STW_BITS-1:0]  ld_word,
    input  logic                 alu_en,
    input  logic                 alu_z,
    input  logic                 alu_c,
    input  logic                 alu_n,
    input  logic                 alu_ovr,
    input  logic [SEL_BITS-1:0]  cond_sel,
    output logic                 cond_out,
    input  logic                 save_en,
    output logic [SAVE_BITS-1:0] save_bus
);
    localparam int PAD_BITS = SAVE_BITS - STW_BITS;

    stword_t   cur_q;
    stword_t   nxt_d;
    aluflags_t alu_in;

    assign alu_in = '{zr: alu_z, cy: alu_c, neg: alu_n, ovr: alu_ovr};

    status_next u_next (
        .cur     (cur_q),
        .op      (st_op_e'(op)),
        .grp     (grp),
        .ld_word (ld_word),
        .alu_en  (alu_en),
        .alu     (alu_in),
        .nxt     (nxt_d)
    );

    status_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_d),
        .q   (cur_q)
    );

    status_cond u_cond (
        .clk (clk),
        .rst (rst),
        .st  (cur_q),
        .sel (cond_sel),
        .tst (cond_out)
    );

    assign save_bus = save_en ? {{PAD_BITS{1'b0}}, cur_q} : '0;

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!alu_en && op == 2'd0) |=> $stable(cur_q));

    // R8
    set_beats_alu_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd1 && grp == GRP_ARITH) |=> (cur_q[3:0] == 4'hF));

    // R3
    clr_arith_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 2'd2 && grp == GRP_ARITH) |=> (cur_q[3:0] == 4'h0));

    // R11
    save_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        save_bus[SAVE_BITS-1:STW_BITS] == '0);

    // R11
    save_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !save_en |-> (save_bus == '0));
endmodule

// File: tb/status_unit_bench.sv
module status_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op;
    logic [4:0]  grp;
    logic [7:0]  ld_word;
    logic        alu_en, alu_z, alu_c, alu_n, alu_ovr;
    logic [3:0]  cond_sel;
    logic        cond_out;
    logic        save_en;
    logic [15:0] save_bus;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_w;
    bit done = 1'b0;

    always #4 clk = ~clk;

    status_unit u_status_unit (
        .clk(clk), .rst(rst), .op(op), .grp(grp), .ld_word(ld_word),
        .alu_en(alu_en), .alu_z(alu_z), .alu_c(alu_c), .alu_n(alu_n),
        .alu_ovr(alu_ovr), .cond_sel(cond_sel), .cond_out(cond_out),
        .save_en(save_en), .save_bus(save_bus)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock with given stimulus; bench model updates exp_w from the requirements
    task automatic step(input logic [1:0] o, input logic [4:0] g, input logic [7:0] ld,
                        input logic en, input logic [3:0] fl);
        logic [7:0] m;
        @(negedge clk);
        op = o; grp = g; ld_word = ld; alu_en = en;
        {alu_ovr, alu_n, alu_c, alu_z} = fl;
        case (g)
            5'd3:    m = 8'h0F;
            5'd5:    m = 8'h10;
            5'd6:    m = 8'h20;
            5'd9:    m = 8'h40;
            5'd10:   m = 8'h80;
            default: m = 8'h00;
        endcase
        if (en) exp_w[3:0] = fl;
        if (o == 2'd1) exp_w = exp_w | m;
        if (o == 2'd2) exp_w = exp_w & ~m;
        if (o == 2'd3) exp_w = ld;
        @(negedge clk);
        op = 2'd0; alu_en = 1'b0;
    endtask

    task automatic check_word(input string req);
        save_en = 1'b1;
        #1;
        check16(req, save_bus, {8'h00, exp_w});
    endtask

    task automatic check_conds(input string req);
        logic e;
        logic z, c, n, v;
        {v, n, c, z} = exp_w[3:0];
        for (int s = 0; s < 16; s++) begin
            cond_sel = s[3:0];
            #1;
            case (s)
                0:  e = (n != v) || z;
                1:  e = (n != v);
                2:  e = z;
                3:  e = v;
                4:  e = !c || z;
                5:  e = c;
                6:  e = z || c;
                7:  e = n;
                8:  e = exp_w[4];
                9:  e = exp_w[5];
                10: e = exp_w[6];
                11: e = exp_w[7];
                default: e = 1'b0;
            endcase
            check16(s >= 12 ? "R10" : req, {15'd0, cond_out}, {15'd0, e});
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        op = 0; grp = 0; ld_word = 8'hFF; alu_en = 1'b1;
        {alu_ovr, alu_n, alu_c, alu_z} = 4'hF;
        cond_sel = 0; save_en = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; alu_en = 1'b0;
        exp_w = 8'h00;
        check_word("R1");
    endtask

    task automatic t_set_clr;
        step(2'd1, 5'd3, 8'h00, 1'b0, 4'h0);  check_word("R2");
        step(2'd1, 5'd5, 8'h00, 1'b0, 4'h0);  check_word("R2");
        step(2'd1, 5'd9, 8'h00, 1'b0, 4'h0);  check_word("R2");
        step(2'd1, 5'd6, 8'h00, 1'b0, 4'h0);  check_word("R2");
        step(2'd1, 5'd10, 8'h00, 1'b0, 4'h0); check_word("R2");
        step(2'd2, 5'd6, 8'h00, 1'b0, 4'h0);  check_word("R3");
        step(2'd2, 5'd3, 8'h00, 1'b0, 4'h0);  check_word("R3");
        step(2'd2, 5'd10, 8'h00, 1'b0, 4'h0); check_word("R3");
        step(2'd2, 5'd5, 8'h00, 1'b0, 4'h0);  check_word("R3");
        step(2'd2, 5'd9, 8'h00, 1'b0, 4'h0);  check_word("R3");
    endtask

    task automatic t_bad_codes;
        step(2'd3, 5'd0, 8'h5A, 1'b0, 4'h0);  check_word("R5");
        for (int g = 0; g < 32; g++) begin
            if (g != 3 && g != 5 && g != 6 && g != 9 && g != 10) begin
                step(2'd1, g[4:0], 8'h00, 1'b0, 4'h0);
                step(2'd2, g[4:0], 8'h00, 1'b0, 4'h0);
            end
        end
        exp_w = 8'h5A; // R4: unchanged from load
        check_word("R4");
    endtask

    task automatic t_alu;
        step(2'd3, 5'd0, 8'hA0, 1'b0, 4'h0); check_word("R5");
        step(2'd0, 5'd0, 8'h00, 1'b1, 4'h9); check_word("R6");
        step(2'd0, 5'd0, 8'h00, 1'b1, 4'h6); check_word("R6");
        step(2'd0, 5'd0, 8'h00, 1'b0, 4'hF); check_word("R7");
        step(2'd0, 5'd0, 8'h00, 1'b0, 4'h0); check_word("R7");
    endtask

    task automatic t_collide;
        step(2'd1, 5'd3, 8'h00, 1'b1, 4'h0);  check_word("R8");
        step(2'd2, 5'd3, 8'h00, 1'b1, 4'hF);  check_word("R8");
        step(2'd3, 5'd0, 8'h3C, 1'b1, 4'h3);  check_word("R8");
        step(2'd1, 5'd5, 8'h00, 1'b1, 4'h5);  check_word("R8");
        step(2'd2, 5'd10, 8'h00, 1'b1, 4'hA); check_word("R8");
    endtask

    task automatic t_conds;
        logic [7:0] pats [6] = '{8'h00, 8'h0F, 8'h02, 8'h09, 8'hF4, 8'h5B};
        foreach (pats[i]) begin
            step(2'd3, 5'd0, pats[i], 1'b0, 4'h0);
            check_conds("R9");
        end
    endtask

    task automatic t_save;
        step(2'd3, 5'd0, 8'hC3, 1'b0, 4'h0);
        check_word("R11");
        save_en = 1'b0;
        #1;
        check16("R11", save_bus, 16'h0000);
        save_en = 1'b1;
    endtask

    initial begin
        t_reset();
        t_set_clr();
        t_bad_codes();
        t_alu();
        t_collide();
        t_conds();
        t_save();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule